// File: doc/BRIEF.md
# Execute Packet Splitter

This block sits between an instruction fetch stage and a set of functional-unit decoders. It takes one 256-bit fetch word holding eight 32-bit instruction slots. It then hands the slots downstream in groups that are meant to issue together. Bit 0 of every instruction is a link flag. A 1 ties the following slot into the same group. A 0 closes the group, so the next slot opens a new one. Groups are taken from slot 0 upward, and one group leaves per clock.

Both data sides use a valid/ready handshake. On the fetch side, `fetch_req` acts as ready. A fetch word is taken on any rising edge where `fetch_req` and `fetch_valid` are both high. `fetch_req` is high only while the block holds no fetch word. On the dispatch side, a group moves on only on an edge where `disp_valid` and `disp_ready` are both high. While `disp_ready` is low, the presented group stays unchanged and no later group is presented. The downstream stage may drop `disp_ready` for any number of cycles.

Top module: `vliw_pkt_splitter`

## Requirements
- R1: After synchronous reset (`rst` high at a rising edge), `fetch_req` is 1, `disp_valid` is 0 and `chain_err` is 0.
- R2: A fetch word accepted at an edge (`fetch_req` and `fetch_valid` high) is presented from the next cycle with `disp_valid`=1 and `disp_start`=0. `fetch_req` stays 0 while any group of it is undispatched.
- R3: The group starting at slot s runs through the first slot e≥s whose bit 0 is 0. If no such slot exists, it runs through slot 7. `disp_mask` has bits s..e set and all others clear, and `disp_start` equals s.
- R4: `disp_words` bits [32i+31:32i] carry slot i of the fetch word when mask bit i is set, and are zero otherwise.
- R5: When a group ending at slot e<7 is accepted, the next cycle presents the group starting at slot e+1.
- R6: While `disp_valid` is 1 and `disp_ready` is 0, `disp_valid`, `disp_mask`, `disp_start` and `disp_words` hold their values into the next cycle.
- R7: Slot 7 always closes a group. `disp_last` is 1 exactly when the presented group includes slot 7. `chain_err` is 1 exactly when that group is presented and slot 7 has bit 0 set to 1.
- R8: The cycle after the group containing slot 7 is accepted, `disp_valid` is 0 and `fetch_req` is 1.
- R9: `fetch_valid` and `fetch_data` are ignored while `fetch_req` is 0. The presented words stay those of the fetch word already held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fetch_req | output | 1 | Ready for a new fetch word |
| fetch_valid | input | 1 | Fetch word valid |
| fetch_data | input | 256 | Eight instruction slots, slot i in bits [32i+31:32i] |
| disp_valid | output | 1 | A group is presented |
| disp_ready | input | 1 | Downstream takes the presented group |
| disp_mask | output | 8 | Slots belonging to the presented group |
| disp_start | output | 3 | Index of the group's first slot |
| disp_words | output | 256 | Slot words of the group, non-member slots zeroed |
| disp_last | output | 1 | Group includes slot 7 |
| chain_err | output | 1 | Slot 7 carries a set link flag |

## Verification
The dispatch outputs come from registers with no path from the inputs. They are therefore due one edge after a fetch is accepted, and one edge after each accepted group. `fetch_req` returns one edge after the closing group is accepted. The bench drives inputs at falling edges and reads outputs at the next falling edge. Each result is therefore read exactly one rising edge after its cause. A held group is read again after a stall cycle, to confirm it has not changed.

// File: rtl/vpd_pkg.sv
package vpd_pkg;
  localparam int SLOT_N = 8;
  localparam int WORD_W = 32;
endpackage

// File: rtl/vpd_chain_scan.sv
module vpd_chain_scan #(
  parameter int N  = 8,
  localparam int SW = $clog2(N)
) (
  input  logic [N-1:0]  link,
  input  logic [SW-1:0] start,
  output logic [N-1:0]  mask,
  output logic [SW-1:0] end_idx,
  output logic          open_tail
);
  logic found;

  always_comb begin
    end_idx = SW'(N - 1);
    found   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!found && i >= int'(start) && !link[i]) begin
        end_idx = SW'(i);
        found   = 1'b1;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++)
      mask[i] = (i >= int'(start)) && (i <= int'(end_idx));
  end

  assign open_tail = (int'(end_idx) == N - 1) && link[N-1];
endmodule

// File: rtl/vpd_hold_reg.sv
module vpd_hold_reg #(
  parameter int N  = 8,
  parameter int W  = 32,
  localparam int SW = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [N*W-1:0] load_data,
  input  logic           adv,
  input  logic           adv_last,
  input  logic [SW-1:0]  adv_start,
  output logic           full,
  output logic [N*W-1:0] data,
  output logic [SW-1:0]  start
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full  <= 1'b0;
      start <= '0;
    end else if (!full && load) begin
      full  <= 1'b1;
      data  <= load_data;
      start <= '0;
    end else if (full && adv) begin
      if (adv_last) full  <= 1'b0;
      else          start <= adv_start;
    end
  end
endmodule

// File: rtl/vpd_word_gate.sv
module vpd_word_gate #(
  parameter int N = 8,
  parameter int W = 32
) (
  input  logic [N*W-1:0] words_in,
  input  logic [N-1:0]   keep,
  output logic [N*W-1:0] words_out
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    assign words_out[g*W +: W] = keep[g] ? words_in[g*W +: W] : '0;
  end
endmodule

// File: rtl/vliw_pkt_splitter.sv
module vliw_pkt_splitter
  import vpd_pkg::*;
#(
  parameter int N  = SLOT_N,
  parameter int W  = WORD_W,
  localparam int SW = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst,
  output logic           fetch_req,
  input  logic           fetch_valid,
  input  logic [N*W-1:0] fetch_data,
  output logic           disp_valid,
  input  logic           disp_ready,
  output logic [N-1:0]   disp_mask,
  output logic [SW-1:0]  disp_start,
  output logic [N*W-1:0] disp_words,
  output logic           disp_last,
  output logic           chain_err
);
  logic           full;
  logic [N*W-1:0] held;
  logic [SW-1:0]  cur_start;
  logic [N-1:0]   link;
  logic [N-1:0]   grp_mask;
  logic [SW-1:0]  grp_end;
  logic           open_tail;

  for (genvar g = 0; g < N; g++) begin : g_link
    assign link[g] = held[g*W];
  end

  vpd_chain_scan #(.N(N)) u_scan (
    .link(link), .start(cur_start), .mask(grp_mask),
    .end_idx(grp_end), .open_tail(open_tail)
  );

  vpd_hold_reg #(.N(N), .W(W)) u_hold (
    .clk(clk), .rst(rst),
    .load(fetch_valid), .load_data(fetch_data),
    .adv(disp_ready), .adv_last(grp_mask[N-1]),
    .adv_start(SW'(grp_end + 1'b1)),
    .full(full), .data(held), .start(cur_start)
  );

  vpd_word_gate #(.N(N), .W(W)) u_gate (
    .words_in(held), .keep(grp_mask), .words_out(disp_words)
  );

  assign fetch_req  = !full;
  assign disp_valid = full;
  assign disp_mask  = grp_mask;
  assign disp_start = cur_start;
  assign disp_last  = full && grp_mask[N-1];
  assign chain_err  = full && open_tail;
endmodule

// File: rtl/vpd_checker.sv
module vpd_checker #(
  parameter int N = 8,
  parameter int W = 32,
  localparam int SW = $clog2(N)
) (
  input logic           clk,
  input logic           rst,
  input logic           fetch_req,
  input logic           disp_valid,
  input logic           disp_ready,
  input logic [N-1:0]   disp_mask,
  input logic [SW-1:0]  disp_start,
  input logic [N*W-1:0] disp_words,
  input logic           disp_last,
  input logic           chain_err
);
  // R2 / R8: never request while holding a fetch word
  a_r2_no_req_while_busy: assert property (@(posedge clk) disable iff (rst)
    disp_valid |-> !fetch_req);

  // R3: the group is non-empty and begins at disp_start
  a_r3_mask_from_start: assert property (@(posedge clk) disable iff (rst)
    disp_valid |-> (disp_mask != '0) && disp_mask[disp_start]);

  // R5: the next group begins right after the accepted one
  a_r5_next_start: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && disp_ready && !disp_last) |=>
      (disp_valid && int'(disp_start) ==
        int'($past(disp_start)) + $countones($past(disp_mask))));

  // R6: a stalled group holds
  a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && !disp_ready) |=>
      (disp_valid && $stable(disp_mask) && $stable(disp_start) && $stable(disp_words)));

  // R7: error flag only with the group holding slot 7
  a_r7_err_at_tail: assert property (@(posedge clk) disable iff (rst)
    chain_err |-> (disp_last && disp_mask[N-1] && disp_words[(N-1)*W]));

  // R8: closing group accepted -> back to requesting
  a_r8_refetch: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && disp_ready && disp_last) |=> (fetch_req && !disp_valid));
endmodule

bind vliw_pkt_splitter vpd_checker #(.N(N), .W(W)) u_vpd_checker (
  .clk(clk), .rst(rst), .fetch_req(fetch_req), .disp_valid(disp_valid),
  .disp_ready(disp_ready), .disp_mask(disp_mask), .disp_start(disp_start),
  .disp_words(disp_words), .disp_last(disp_last), .chain_err(chain_err)
);

// File: tb/tb_vliw_pkt_splitter.sv
module tb_vliw_pkt_splitter;
  logic         clk = 0;
  logic         rst;
  logic         fetch_req;
  logic         fetch_valid;
  logic [255:0] fetch_data;
  logic         disp_valid;
  logic         disp_ready;
  logic [7:0]   disp_mask;
  logic [2:0]   disp_start;
  logic [255:0] disp_words;
  logic         disp_last;
  logic         chain_err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  vliw_pkt_splitter dut (
    .clk(clk), .rst(rst), .fetch_req(fetch_req), .fetch_valid(fetch_valid),
    .fetch_data(fetch_data), .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_mask(disp_mask), .disp_start(disp_start), .disp_words(disp_words),
    .disp_last(disp_last), .chain_err(chain_err)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [255:0] act,
                     input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [255:0] make_word(input int p);
    logic [255:0] d;
    for (int i = 0; i < 8; i++) begin
      d[i*32 +: 32] = (32'hA5C30000 ^ 32'((p * 8 + i) << 1)) | 32'(p[i]);
    end
    return d;
  endfunction

  initial begin
    logic [255:0] fw, exp_w;
    logic [7:0]   m;
    int s, e, k;
    bit stall;
    rst = 1; fetch_valid = 0; fetch_data = '0; disp_ready = 0;
    @(negedge clk); @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(fetch_req == 1'b1, "R1 fetch_req", 256'(fetch_req), 256'd1);
    chk(disp_valid == 1'b0, "R1 disp_valid", 256'(disp_valid), 256'd0);
    chk(chain_err == 1'b0, "R1 chain_err", 256'(chain_err), 256'd0);

    for (int p = 0; p < 256; p++) begin
      fw = make_word(p);
      fetch_valid = 1; fetch_data = fw;
      @(negedge clk);
      // R9: junk offered while busy must be ignored
      fetch_valid = p[0]; fetch_data = ~fw;
      chk(disp_valid == 1'b1, "R2 valid after fetch", 256'(disp_valid), 256'd1);
      chk(disp_start == 3'd0, "R2 first start", 256'(disp_start), 256'd0);
      chk(fetch_req == 1'b0, "R2 no request while busy", 256'(fetch_req), 256'd0);
      s = 0; k = 0;
      while (1) begin
        e = 7;
        for (int i = 7; i >= s; i--) if (!p[i]) e = i;
        m = '0; exp_w = '0;
        for (int i = s; i <= e; i++) begin
          m[i] = 1'b1;
          exp_w[i*32 +: 32] = fw[i*32 +: 32];
        end
        stall = ((p + k) % 3) == 0;
        if (stall) begin
          disp_ready = 0;
          @(negedge clk);
          chk(disp_valid && disp_mask == m && disp_words == exp_w, "R6 hold on stall",
              {disp_words[247:0], disp_mask}, {exp_w[247:0], m});
        end
        chk(disp_start == 3'(s), "R3/R5 start slot", 256'(disp_start), 256'(s));
        chk(disp_mask == m, "R3 mask", 256'(disp_mask), 256'(m));
        chk(disp_words == exp_w, "R4/R9 words", disp_words, exp_w);
        chk(disp_last == (e == 7), "R7 last", 256'(disp_last), 256'(e == 7));
        chk(chain_err == (e == 7 && p[7]), "R7 chain_err", 256'(chain_err),
            256'(e == 7 && p[7]));
        disp_ready = 1;
        @(negedge clk);
        disp_ready = 0;
        if (e == 7) break;
        s = e + 1; k++;
      end
      fetch_valid = 0;
      chk(fetch_req == 1'b1 && disp_valid == 1'b0, "R8 refetch",
          {254'd0, fetch_req, disp_valid}, 256'd2);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule